// File: doc/BRIEF.md
# Multiplexed External Data Bus Sequencer

This block is the engine that an 8051-style core uses to reach external data memory. Each request runs one read or one write on a multiplexed bus. An 8-bit shared port carries the low address byte first and then the data byte. A second 8-bit port carries the high address byte. An address latch strobe, `ale`, lets an external latch capture the low byte. Active-low read and write strobes frame the data transfer. Every edge falls on a whole number of clock periods.

A cycle takes twelve clock periods, numbered 0 to 11 from the edge that accepts the request:

| Period | What happens |
|--------|--------------|
| 0 and 1 | `ale` is high. |
| 1 and 2 | The low address is on the shared port. |
| 5 to 10 | The strobe is low. |
| 4 to 11 | Write data is on the shared port (writes only). |
| 11 | `done` pulses. |

Read data is captured at the edge that closes period 10. A request is held off while a cycle runs. It is taken at the edge that ends the done period, so the next `ale` rises one period after the strobe returns high.

Top module: `xbus_seq`

## Requirements
- R1: After reset and whenever no cycle runs, `ale` is 0, `rd_n` and `wr_n` are 1, `p0_oe` is 0 and `done` is 0.
- R2: `ale` is high for exactly periods 0 and 1 of a cycle, so it is high for two periods and falls at the start of period 2.
- R3: The low address byte is driven on `p0_out` with `p0_oe` high in periods 1 and 2. That is one period before `ale` falls and one period after it.
- R4: `p2_out` carries the high address byte `addr[15:8]` of the running cycle in every period of that cycle.
- R5: The strobe for the cycle's direction is low in periods 5 to 10. It falls three periods after `ale` falls and stays low for six periods.
- R6: On a write, `wdata` is driven on `p0_out` with `p0_oe` high from period 4 to period 11. That is one period before `wr_n` falls until one period after it rises.
- R7: On a read, `p0_oe` is 0 from period 3 to the end of the cycle, so the port is released while `rd_n` is low.
- R8: On a read, `rdata` takes the value of `p0_in` present in period 10, the last period before `rd_n` rises. A value on `p0_in` in period 11 is not taken. A write leaves `rdata` unchanged.
- R9: `done` is high for one period only, in period 11, the period after the strobe rises.
- R10: A request raised while a cycle runs does not change that cycle's outputs. It starts at the edge that ends the done period, so its `ale` is high one period after the strobe rose.
- R11: Only the strobe that matches `we` goes low (1 = write, 0 = read), and `rd_n` and `wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one period is the timing unit |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Cycle request; sampled when idle or in the done period |
| we | input | 1 | Direction: 1 = write, 0 = read |
| addr | input | 16 | External data address |
| wdata | input | 8 | Byte to write |
| p0_in | input | 8 | Value read back from the shared port |
| p0_out | output | 8 | Shared port drive: low address, then write data |
| p0_oe | output | 1 | Shared port output enable |
| p2_out | output | 8 | High address byte port |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-period pulse in the last period of a cycle |

## Verification
Each cycle's period count starts at the rising edge that accepts `req`. The bench counts periods from that edge and samples every output on the falling edge inside each period, comparing against a per-period expectation function. Strobes, port drive and `ale` are due in the same period in which the table above places them. `rdata` is due in period 11, one edge after the capture in period 10. Changing `p0_in` in periods 10 and 11 shows which edge is sampled. A request queued mid-cycle must show `ale` high in the very next period after `done`.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int T_ALE = 2,
  parameter int T_GAP = 3,
  parameter int T_STB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] p0_in,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [AW-DW-1:0] p2_out,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          done
);
  localparam int S_ADDR = T_ALE - 1;
  localparam int E_ADDR = T_ALE;
  localparam int S_STB  = T_ALE + T_GAP;
  localparam int E_STB  = S_STB + T_STB - 1;
  localparam int S_DATA = S_STB - 1;
  localparam int LAST   = E_STB + 1;
  localparam int CW     = $clog2(LAST + 1);

  logic          busy, we_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          last, start, in_addr, in_data, stb;

  assign last  = busy && (cnt == CW'(LAST));
  assign start = req && (!busy || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      we_q  <= 1'b0;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        a_q  <= addr;
        d_q  <= wdata;
        we_q <= we;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (busy && !we_q && cnt == CW'(E_STB))
        rdata <= p0_in;
    end
  end

  assign in_addr = busy && cnt >= CW'(S_ADDR) && cnt <= CW'(E_ADDR);
  assign in_data = busy && we_q && cnt >= CW'(S_DATA) && cnt <= CW'(LAST);
  assign stb     = busy && cnt >= CW'(S_STB) && cnt <= CW'(E_STB);

  assign ale    = busy && cnt < CW'(T_ALE);
  assign rd_n   = !(stb && !we_q);
  assign wr_n   = !(stb && we_q);
  assign p0_oe  = in_addr || in_data;
  assign p0_out = in_addr ? a_q[DW-1:0] : (in_data ? d_q : '0);
  assign p2_out = a_q[AW-1:DW];
  assign done   = last;
endmodule

module xbus_seq_chk #(
  parameter int T_STB = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       p0_oe,
  input logic [7:0] p2_out,
  input logic       done
);
  logic [7:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lowcnt <= '0;
    else if (!rd_n || !wr_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> $past(ale, 2));
  p_no_ale_in_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ale);
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> lowcnt == 8'(T_STB));
  p_read_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);
  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_high_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!rd_n || !wr_n) && (!rd_n || !wr_n)) |-> $stable(p2_out));
endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .p0_oe(p0_oe), .p2_out(p2_out), .done(done)
);

// File: tb/tb_xbus_seq.sv
`timescale 1ns/1ps
module tb_xbus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, p0_in = '0;
  logic [7:0]  p0_out, p2_out, rdata;
  logic        p0_oe, ale, rd_n, wr_n, done;

  int errors = 0, checks = 0;
  logic [7:0] last_rd = 8'h00;

  always #10 clk = ~clk;

  xbus_seq dut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata),
    .done(done));

  task automatic ck(string r, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic e_ale(int k);  return k < 2; endfunction
  function automatic logic e_adr(int k);  return k == 1 || k == 2; endfunction
  function automatic logic e_stb(int k);  return k >= 5 && k <= 10; endfunction
  function automatic logic e_dat(logic w, int k); return w && k >= 4 && k <= 11; endfunction

  task automatic check_idle();
    ck("R1", "ale", 16'(ale), 16'h0);
    ck("R1", "rd_n", 16'(rd_n), 16'h1);
    ck("R1", "wr_n", 16'(wr_n), 16'h1);
    ck("R1", "p0_oe", 16'(p0_oe), 16'h0);
    ck("R1", "done", 16'(done), 16'h0);
  endtask

  // Called right after the accepting edge; walks periods 0..11.
  // If nxt, a new request is raised in period 3 (R10).
  task automatic walk(logic w, logic [15:0] a, logic [7:0] d, logic nxt,
                      logic nw, logic [15:0] na, logic [7:0] nd);
    logic [7:0] tgt;
    tgt = 8'($urandom);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0) req = 1'b0;
      if (k == 3 && nxt) begin req = 1'b1; we = nw; addr = na; wdata = nd; end
      p0_in = (k == 10) ? tgt : 8'($urandom);
      ck("R2", "ale", 16'(ale), 16'(e_ale(k)));
      ck("R4", "p2_out", 16'(p2_out), 16'(a[15:8]));
      ck("R5", "rd_n", 16'(rd_n), 16'(!(e_stb(k) && !w)));
      ck("R11", "wr_n", 16'(wr_n), 16'(!(e_stb(k) && w)));
      ck(w ? "R6" : "R7", "p0_oe", 16'(p0_oe), 16'(e_adr(k) || e_dat(w, k)));
      if (e_adr(k)) ck("R3", "p0_out addr", 16'(p0_out), 16'(a[7:0]));
      if (e_dat(w, k)) ck("R6", "p0_out data", 16'(p0_out), 16'(d));
      ck("R9", "done", 16'(done), 16'(k == 11));
      if (k == 11) begin
        if (!w) last_rd = tgt;
        ck("R8", "rdata", 16'(rdata), 16'(last_rd));
      end
    end
  endtask

  task automatic one(logic w, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    walk(w, a, d, 1'b0, 1'b0, 16'h0, 8'h0);
    @(negedge clk);
    check_idle();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle();
    rst_n = 1'b1;
    @(negedge clk);
    check_idle();

    one(1'b0, 16'h12A5, 8'h00);
    one(1'b1, 16'hFF00, 8'h5A);
    one(1'b1, 16'h0000, 8'hFF);
    one(1'b0, 16'hFFFF, 8'h00);

    // R10: request queued mid-cycle starts right after done
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'hBEEF; wdata = 8'hC3;
    @(posedge clk);
    walk(1'b1, 16'hBEEF, 8'hC3, 1'b1, 1'b0, 16'h4321, 8'h99);
    @(posedge clk);
    walk(1'b0, 16'h4321, 8'h99, 1'b0, 1'b0, 16'h0, 8'h0);
    @(negedge clk);
    check_idle();

    for (int i = 0; i < 40; i++) begin
      logic w;
      logic [15:0] a;
      logic [7:0] d;
      w = 1'($urandom);
      a = 16'($urandom);
      d = 8'($urandom);
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        walk(w, a, d, 1'b1, ~w, ~a, ~d);
        @(posedge clk);
        walk(~w, ~a, ~d, 1'b0, 1'b0, 16'h0, 8'h0);
        @(negedge clk);
        check_idle();
      end else begin
        one(w, a, d);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule